// File: doc/BRIEF.md
# Fetch-Increment Control Sequencer

This block paces the fetch of each instruction and the advance of the program counter. An eight-step cyclic sequencer produces five derived timing windows. The first two windows decode into the bus strobes for the fetch. Those strobes drive the program counter onto the address bus, read memory, and load the instruction register and the increment register. The middle windows decode into the strobes that drive the incrementer onto the address bus and load the program counter back.

The last three windows are brought out as ports, so that the execution logic can run the fetched instruction while the counter increment completes. A fetch-window marker tells the instruction-length logic when to arm its eight-step abort. The memory, the registers, the incrementer and the instruction decode are outside the block.

Bus drivers are held across every load that samples them. The two address-bus drivers are separated by an empty step, so they never overlap. All strobes are registered and change only just after a clock edge.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous reset (`rst` high) puts the sequencer in idle at step S1 with every strobe, pulse and marker output low.
- R2: While idle, the sequencer stays idle with all outputs low as long as `run_en` is low. The first clock edge that samples `run_en` high starts an active cycle at S1, visible just after that edge.
- R3: An active cycle steps S1, S2, ..., S8 on successive edges and ignores `run_en` until S8. At the end of S8 it restarts at S1 if `run_en` is high, and otherwise returns to idle.
- R4: The execution pulses `pulse_c` (S4 to S6), `pulse_d` (S5 only) and `pulse_e` (S6 to S8) are high in exactly those steps.
- R5: `sel_pc` and `mem_rd` are high in S1 and S2 only.
- R6: `ld_ir` and `ld_inc` are high in S2 only: one step wide, and inside the `sel_pc`/`mem_rd` window with at least one step of select before them.
- R7: S3 drives no address-bus select. `sel_pc` and `sel_inc` are never high together, and exactly one empty step lies between the fall of `sel_pc` and the rise of `sel_inc`.
- R8: `sel_inc` is high in S4 and S5, and `ld_pc` is high in S5 only, with `sel_inc` asserted one step before `ld_pc`.
- R9: `fetch_mark` is high during the fetch window S1 to S3 of every active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable, sampled at idle and at the end of S8 |
| sel_pc | output | 1 | Drive program counter onto address bus |
| mem_rd | output | 1 | Read memory onto data bus |
| ld_ir | output | 1 | Load instruction register |
| ld_inc | output | 1 | Load increment register |
| sel_inc | output | 1 | Drive incrementer onto address bus |
| ld_pc | output | 1 | Load program counter |
| fetch_mark | output | 1 | Fetch window marker for instruction-length abort |
| pulse_c | output | 1 | Execution pulse C (S4 to S6) |
| pulse_d | output | 1 | Execution pulse D (S5) |
| pulse_e | output | 1 | Execution pulse E (S6 to S8) |

## Verification
The hardest cases to reach are the points where `run_en` changes exactly at the S8 boundary or part way through a cycle. The sequencer must ignore a mid-cycle drop, yet must honour the level sampled at the end of S8. The stimulus sweeps a one-step low pulse on `run_en` across every one of the eight step positions. It also toggles `run_en` at the idle edge and applies a reset in the middle of a cycle. Every output is compared on every cycle against an arithmetic model of the step index.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef struct packed {
      logic a;
      logic b;
      logic c;
      logic d;
      logic e;
   } fseq_pulse_t;

   typedef struct packed {
      logic sel_pc;
      logic mem_rd;
      logic ld_ir;
      logic ld_inc;
      logic sel_inc;
      logic ld_pc;
      logic mark;
   } fseq_strobe_t;

   localparam int FSEQ_NPULSE = 5;

endpackage

// File: rtl/fseq_counter.sv
module fseq_counter #(
   parameter int SEQ_LEN = 8,
   localparam int IW = $clog2(SEQ_LEN)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run_en,
   output logic [IW-1:0] idx_q,
   output logic          act_q,
   output logic [IW-1:0] idx_nxt,
   output logic          act_nxt
);
   localparam logic [IW-1:0] LAST = IW'(SEQ_LEN - 1);

   always_comb begin
      idx_nxt = idx_q;
      act_nxt = act_q;
      if (rst) begin
         idx_nxt = '0;
         act_nxt = 1'b0;
      end else if (!act_q) begin
         idx_nxt = '0;
         act_nxt = run_en;
      end else if (idx_q == LAST) begin
         idx_nxt = '0;
         act_nxt = run_en;
      end else begin
         idx_nxt = idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      idx_q <= idx_nxt;
      act_q <= act_nxt;
   end

   // R3: step advances by one inside an active cycle
   assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
      (act_q && idx_q != LAST) |=> (act_q && idx_q == $past(idx_q) + 1'b1));
   // R2: idle parks at step zero
   assert_idle_parked_R2: assert property (@(posedge clk) disable iff (rst)
      !act_q |-> idx_q == '0);
endmodule

// File: rtl/fseq_pulse_dec.sv
module fseq_pulse_dec
   import fseq_pkg::*;
#(
   parameter int SEQ_LEN = 8,
   parameter int GAP     = 1,
   localparam int IW = $clog2(SEQ_LEN)
) (
   input  logic [IW-1:0] idx,
   input  logic          act,
   output fseq_pulse_t   pulses
);
   // zero-based window bounds: A, B, C, D, E
   localparam int LO [FSEQ_NPULSE] = '{0, 1, 2 + GAP, 3 + GAP, 4 + GAP};
   localparam int HI [FSEQ_NPULSE] = '{1 + GAP, 1, 4 + GAP, 3 + GAP, SEQ_LEN - 1};

   logic [FSEQ_NPULSE-1:0] win;
   int                     pos;

   assign pos = int'(idx);

   for (genvar gi = 0; gi < FSEQ_NPULSE; gi++) begin : g_win
      assign win[gi] = act && (pos >= LO[gi]) && (pos <= HI[gi]);
   end

   assign pulses.a = win[0];
   assign pulses.b = win[1];
   assign pulses.c = win[2];
   assign pulses.d = win[3];
   assign pulses.e = win[4];
endmodule

// File: rtl/fseq_strobe_dec.sv
module fseq_strobe_dec
   import fseq_pkg::*;
#(
   parameter int SEQ_LEN = 8,
   parameter int GAP     = 1,
   localparam int IW = $clog2(SEQ_LEN)
) (
   input  logic [IW-1:0] idx,
   input  fseq_pulse_t   pulses,
   output fseq_strobe_t  strobes
);
   localparam int PC_END  = 1;
   localparam int INC_END = 3 + GAP;

   int pos;
   assign pos = int'(idx);

   always_comb begin
      strobes.sel_pc  = pulses.a && (pos <= PC_END);
      strobes.mem_rd  = pulses.a && (pos <= PC_END);
      strobes.ld_ir   = pulses.b;
      strobes.ld_inc  = pulses.b;
      strobes.sel_inc = pulses.c && (pos <= INC_END);
      strobes.ld_pc   = pulses.d;
      strobes.mark    = pulses.a;
   end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
   import fseq_pkg::*;
#(
   parameter int SEQ_LEN = 8,
   parameter int GAP     = 1,
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic run_en,
   output logic sel_pc,
   output logic mem_rd,
   output logic ld_ir,
   output logic ld_inc,
   output logic sel_inc,
   output logic ld_pc,
   output logic fetch_mark,
   output logic pulse_c,
   output logic pulse_d,
   output logic pulse_e
);
   localparam int IW = $clog2(SEQ_LEN);

   if (GAP < 1) begin : g_bad_gap
      $error("fetch_seq: GAP must be at least one step");
   end
   if (SEQ_LEN < GAP + 5) begin : g_bad_len
      $error("fetch_seq: SEQ_LEN too short for the fetch windows");
   end

   logic [IW-1:0] idx_q, idx_nxt;
   logic          act_q, act_nxt;
   fseq_pulse_t   pls_out;
   fseq_strobe_t  stb_out;

   fseq_counter #(.SEQ_LEN(SEQ_LEN)) u_cnt (
      .clk(clk), .rst(rst), .run_en(run_en),
      .idx_q(idx_q), .act_q(act_q), .idx_nxt(idx_nxt), .act_nxt(act_nxt)
   );

   if (REG_OUT) begin : g_reg
      fseq_pulse_t  pls_n;
      fseq_strobe_t stb_n;
      fseq_pulse_t  pls_r;
      fseq_strobe_t stb_r;

      fseq_pulse_dec #(.SEQ_LEN(SEQ_LEN), .GAP(GAP)) u_pdec (
         .idx(idx_nxt), .act(act_nxt), .pulses(pls_n)
      );
      fseq_strobe_dec #(.SEQ_LEN(SEQ_LEN), .GAP(GAP)) u_sdec (
         .idx(idx_nxt), .pulses(pls_n), .strobes(stb_n)
      );

      always_ff @(posedge clk) begin
         pls_r <= pls_n;
         stb_r <= stb_n;
      end

      assign pls_out = pls_r;
      assign stb_out = stb_r;
   end else begin : g_comb
      fseq_pulse_dec #(.SEQ_LEN(SEQ_LEN), .GAP(GAP)) u_pdec (
         .idx(idx_q), .act(act_q), .pulses(pls_out)
      );
      fseq_strobe_dec #(.SEQ_LEN(SEQ_LEN), .GAP(GAP)) u_sdec (
         .idx(idx_q), .pulses(pls_out), .strobes(stb_out)
      );
   end

   assign sel_pc     = stb_out.sel_pc;
   assign mem_rd     = stb_out.mem_rd;
   assign ld_ir      = stb_out.ld_ir;
   assign ld_inc     = stb_out.ld_inc;
   assign sel_inc    = stb_out.sel_inc;
   assign ld_pc      = stb_out.ld_pc;
   assign fetch_mark = stb_out.mark;
   assign pulse_c    = pls_out.c;
   assign pulse_d    = pls_out.d;
   assign pulse_e    = pls_out.e;

   // R6: fetch loads sit inside the program-counter and memory-read window
   assert_load_held_R6: assert property (@(posedge clk) disable iff (rst)
      (ld_ir || ld_inc) |-> (sel_pc && mem_rd));
   assert_load_setup_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(ld_ir) |-> $past(sel_pc && mem_rd));
   assert_load_single_R6: assert property (@(posedge clk) disable iff (rst)
      ld_ir |=> !ld_ir);
   // R7: address-bus drivers never overlap and are separated by an empty step
   assert_bus_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      !(sel_pc && sel_inc));
   assert_bus_gap_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(sel_pc) |-> !sel_inc);
   // R8: counter load is inside the incrementer select with setup
   assert_pc_load_held_R8: assert property (@(posedge clk) disable iff (rst)
      ld_pc |-> sel_inc);
   assert_pc_load_setup_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(ld_pc) |-> $past(sel_inc));
   // R9: marker accompanies every program-counter select
   assert_mark_window_R9: assert property (@(posedge clk) disable iff (rst)
      sel_pc |-> fetch_mark);
   // R1: outputs quiet the cycle after reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !(sel_pc || mem_rd || ld_ir || ld_inc || sel_inc || ld_pc ||
                fetch_mark || pulse_c || pulse_d || pulse_e));
endmodule

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run_en = 1'b0;
   logic sel_pc, mem_rd, ld_ir, ld_inc, sel_inc, ld_pc, fetch_mark;
   logic pulse_c, pulse_d, pulse_e;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit chk_en = 1'b0;

   always #4 clk = ~clk;

   fetch_seq u_dut (
      .clk(clk), .rst(rst), .run_en(run_en),
      .sel_pc(sel_pc), .mem_rd(mem_rd), .ld_ir(ld_ir), .ld_inc(ld_inc),
      .sel_inc(sel_inc), .ld_pc(ld_pc), .fetch_mark(fetch_mark),
      .pulse_c(pulse_c), .pulse_d(pulse_d), .pulse_e(pulse_e)
   );

   // bench model: step number 1..8 while active
   int m_step = 1;
   bit m_act = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         m_act  <= 1'b0;
         m_step <= 1;
      end else if (!m_act) begin
         m_act  <= run_en;
         m_step <= 1;
      end else if (m_step == 8) begin
         m_act  <= run_en;
         m_step <= 1;
      end else begin
         m_step <= m_step + 1;
      end
   end

   task automatic chk(input string tag, input string nm, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (step %0d active %0b)",
                  tag, nm, act, exp, m_step, m_act);
      end
   endtask

   // gap tracking for R7
   int since_pc = 0;
   bit seen_pc = 1'b0;
   logic prev_inc = 1'b0;

   always @(negedge clk) begin
      if (chk_en) begin
         int s;
         bit a;
         s = m_step;
         a = m_act;
         chk(rst ? "R1" : "R5", "sel_pc",  sel_pc,  a && s <= 2);
         chk(rst ? "R1" : "R5", "mem_rd",  mem_rd,  a && s <= 2);
         chk(rst ? "R1" : "R6", "ld_ir",   ld_ir,   a && s == 2);
         chk(rst ? "R1" : "R6", "ld_inc",  ld_inc,  a && s == 2);
         chk(rst ? "R1" : "R8", "sel_inc", sel_inc, a && (s == 4 || s == 5));
         chk(rst ? "R1" : "R8", "ld_pc",   ld_pc,   a && s == 5);
         chk(rst ? "R1" : "R9", "fetch_mark", fetch_mark, a && s <= 3);
         chk(rst ? "R1" : "R4", "pulse_c", pulse_c, a && s >= 4 && s <= 6);
         chk(rst ? "R1" : "R4", "pulse_d", pulse_d, a && s == 5);
         chk(rst ? "R1" : "R4", "pulse_e", pulse_e, a && s >= 6);
         if (sel_inc && !prev_inc && seen_pc)
            chk("R7", "gap_steps_is_one", since_pc == 1, 1'b1);
         if (sel_pc) begin
            since_pc = 0;
            seen_pc  = 1'b1;
         end else begin
            since_pc++;
         end
         prev_inc = sel_inc;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_en = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      // R2: idle hold with run low
      repeat (6) @(negedge clk);
      // R3: continuous running over several cycles
      run_en = 1'b1;
      repeat (40) @(negedge clk);
      // R3: drop run for a single step at every position of the cycle
      for (int p = 0; p < 8; p++) begin
         run_en = 1'b1;
         repeat (3) @(negedge clk);
         while (!(m_act && m_step == 1)) @(negedge clk);
         repeat (p) @(negedge clk);
         run_en = 1'b0;
         @(negedge clk);
         run_en = 1'b1;
         repeat (20) @(negedge clk);
      end
      // R3: stop cleanly at the boundary, then restart from idle
      run_en = 1'b0;
      repeat (12) @(negedge clk);
      run_en = 1'b1;
      @(negedge clk);
      run_en = 1'b0;
      repeat (12) @(negedge clk);
      // R1: reset in the middle of a cycle
      run_en = 1'b1;
      repeat (13) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      run_en = 1'b0;
      repeat (10) @(negedge clk);
      done = 1'b1;
      chk_en = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule